// File: doc/BRIEF.md
# Time-Base Tap Interval Timers

This block derives two periodic interrupt sources from a free-running 64-bit time base. The sources are a fixed-interval timer and a watchdog interval timer. The time base advances by one on each cycle in which a tick enable is high. Each source watches one bit of the time base, called its tap. The tap position comes from a 2-bit period field in a 32-bit control register. A mode strap selects how that field is decoded. In table mode, the field indexes a per-implementation table of four tap positions, supplied as parameters. In extended mode, a 4-bit extension field is joined to the period field to form a 6-bit code, and the tap is 63 minus that code.

A source raises its event only when its tapped bit rises from 0 to 1. The event sets a sticky bit in a 32-bit status register. Software clears status bits by writing ones to them. Each interrupt output is the registered AND of a status bit and its enable bit in the control register.

A neighbouring decrementer shares both registers. Its expiry pulse sets the decrementer status bit. The block exports that status bit, the decrementer enable bit and the auto-reload bit, and drives the decrementer interrupt.

Top module: `tbt_tap_timers`

## Requirements
- R1: After a synchronous active-high reset, the control register, the status register, the time base and all three interrupt outputs read zero.
- R2: The time base increments by exactly one on each clock edge at which `tick_en` is high, and holds its value otherwise.
- R3: A control write stores the full 32-bit word, which reads back unchanged on `ctrl_q` after the write edge. The control fields are laid out as follows:
  - watchdog period: bits 31:30
  - watchdog reset control: bits 29:28 (stored only)
  - watchdog interrupt enable: bit 27
  - decrementer interrupt enable: bit 26
  - fixed-interval period: bits 25:24
  - fixed-interval interrupt enable: bit 23
  - auto-reload: bit 22
  - watchdog period extension: bits 20:17
  - fixed-interval period extension: bits 16:13
- R4: With `ext_mode` low, each source's tap is entry N of that source's four-entry parameter table, where N is the source's 2-bit period field.
- R5: With `ext_mode` high, each source's tap is 63 minus (period field OR (extension field shifted left by 2)).
- R6: An event occurs only when the tapped time-base bit changes from 0 to 1. A 1-to-0 change causes no event. The event sets the matching sticky status bit: bit 26 for the fixed-interval source and bit 30 for the watchdog. That bit is visible on the edge after the edge that updated the time base.
- R7: A status write clears every status bit at a position where the write data is 1, and leaves every other bit unchanged. The status fields are laid out as follows:
  - enable-next-watchdog: bit 31 (always reads 0)
  - watchdog status: bit 30
  - watchdog reset status: bits 29:28 (always read 0)
  - decrementer status: bit 27
  - fixed-interval status: bit 26
- R8: When an event and a status write that clears the same bit fall on the same edge, the bit remains set.
- R9: A change of the tap position, whether from a control write or from the strap, never produces an event by itself. Later genuine 0-to-1 transitions of the new tap still produce events.
- R10: Each interrupt output is a register loaded with the AND of its status bit and its enable bit. It follows a change of either register one edge later. The pairs are:
  - `fit_irq`: status bit 26 with control bit 23
  - `wdog_irq`: status bit 30 with control bit 27
  - `dec_irq`: status bit 27 with control bit 26
- R11: A high `dec_event` sets status bit 27. The outputs `dec_status`, `dec_irq_en` and `dec_autoreload` present status bit 27, control bit 26 and control bit 22 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Time-base advance enable |
| ext_mode | input | 1 | Period decode strap: 0 table, 1 extended |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control register write data |
| stat_we | input | 1 | Status register write strobe (write-one-to-clear) |
| stat_wdata | input | 32 | Status register write data |
| dec_event | input | 1 | Decrementer expiry pulse from the neighbour block |
| time_base | output | 64 | Current time-base value |
| ctrl_q | output | 32 | Control register contents |
| stat_q | output | 32 | Status register contents |
| fit_irq | output | 1 | Fixed-interval interrupt level |
| wdog_irq | output | 1 | Watchdog interval interrupt level |
| dec_irq | output | 1 | Decrementer interrupt level |
| dec_status | output | 1 | Decrementer status bit |
| dec_irq_en | output | 1 | Decrementer interrupt enable bit |
| dec_autoreload | output | 1 | Auto-reload enable bit |

## Verification
The assertions check several rules on every cycle:
- the time base steps by one or holds
- an event is seen only on a rising tapped bit and never in a cycle where the tap moved
- the status bits stay set until cleared, clear on a write of one, and win against a simultaneous clear
- each interrupt follows its AND one edge later

Tap decoding cannot be seen by a per-cycle property. The bench scenarios show it instead, by ticking the time base up to just below and exactly onto the predicted transitions, in both strap modes. The bench scenarios also cover the absence of events on falling edges and after a retap, the read-back of control fields, and the decrementer sharing.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  localparam int TB_W  = 64;
  localparam int TAP_W = 6;
  localparam int REG_W = 32;

  // control fields
  localparam int C_WD_PER_LO  = 30;
  localparam int C_WD_IEN     = 27;
  localparam int C_DEC_IEN    = 26;
  localparam int C_FI_PER_LO  = 24;
  localparam int C_FI_IEN     = 23;
  localparam int C_AUTORELOAD = 22;
  localparam int C_WD_EXT_LO  = 17;
  localparam int C_FI_EXT_LO  = 13;

  // status fields
  localparam int S_WD_STS  = 30;
  localparam int S_DEC_STS = 27;
  localparam int S_FI_STS  = 26;

  localparam int NSRC  = 2;
  localparam int SRC_FI = 0;
  localparam int SRC_WD = 1;

  typedef enum logic {
    DEC_TABLE = 1'b0,
    DEC_EXT   = 1'b1
  } tap_mode_e;

  function automatic logic [TAP_W-1:0] ext_tap(input logic [1:0] per,
                                               input logic [3:0] per_ext);
    logic [TAP_W-1:0] code;
    code = {per_ext, 2'b00} | {4'b0000, per};
    return TAP_W'(TB_W - 1) - code;
  endfunction
endpackage

// File: rtl/tbt_time_base.sv
module tbt_time_base #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  output logic [W-1:0] tb_q
);
  always_ff @(posedge clk) begin
    if (rst)          tb_q <= '0;
    else if (tick_en) tb_q <= tb_q + W'(1);
  end

  assert_tb_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(tb_q));
  assert_tb_step_R2: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> (tb_q == $past(tb_q) + W'(1)));
endmodule

// File: rtl/tbt_tap_decode.sv
module tbt_tap_decode
  import tbt_pkg::*;
#(
  parameter logic [3:0][TAP_W-1:0] TAPS = {6'd29, 6'd25, 6'd21, 6'd17}
) (
  input  tap_mode_e        mode,
  input  logic [1:0]       per,
  input  logic [3:0]       per_ext,
  output logic [TAP_W-1:0] tap_idx
);
  always_comb begin
    if (mode == DEC_EXT) tap_idx = ext_tap(per, per_ext);
    else                 tap_idx = TAPS[per];
  end
endmodule

// File: rtl/tbt_edge_det.sv
module tbt_edge_det #(
  parameter int W  = 64,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  tb,
  input  logic [IW-1:0] tap_idx,
  output logic          evt
);
  logic          cur_bit;
  logic          prev_bit;
  logic [IW-1:0] prev_idx;
  logic          same_tap;

  assign cur_bit  = tb[tap_idx];
  assign same_tap = (tap_idx == prev_idx);
  assign evt      = same_tap & cur_bit & ~prev_bit;

  // re-sample every cycle; a moved tap just reloads the history
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_bit <= 1'b0;
      prev_idx <= '0;
    end else begin
      prev_bit <= cur_bit;
      prev_idx <= tap_idx;
    end
  end

  assert_no_event_on_retap_R9: assert property (@(posedge clk) disable iff (rst)
    (tap_idx != $past(tap_idx)) |-> !evt);
  assert_event_needs_rise_R6: assert property (@(posedge clk) disable iff (rst)
    evt |-> (tb[tap_idx] && !$past(tb[tap_idx])));
endmodule

// File: rtl/tbt_regs.sv
module tbt_regs
  import tbt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we,
  input  logic [REG_W-1:0] ctrl_wdata,
  input  logic             stat_we,
  input  logic [REG_W-1:0] stat_wdata,
  input  logic             fi_set,
  input  logic             wd_set,
  input  logic             dec_set,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] stat_q,
  output logic             fit_irq,
  output logic             wdog_irq,
  output logic             dec_irq
);
  localparam logic [REG_W-1:0] STS_MASK =
    (REG_W'(1) << S_WD_STS) | (REG_W'(1) << S_DEC_STS) | (REG_W'(1) << S_FI_STS);

  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] stat_nxt;

  always_comb begin
    set_vec = '0;
    set_vec[S_FI_STS]  = fi_set;
    set_vec[S_WD_STS]  = wd_set;
    set_vec[S_DEC_STS] = dec_set;
    clr_vec  = stat_we ? stat_wdata : '0;
    stat_nxt = ((stat_q & ~clr_vec) | set_vec) & STS_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      stat_q   <= '0;
      fit_irq  <= 1'b0;
      wdog_irq <= 1'b0;
      dec_irq  <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_wdata;
      stat_q   <= stat_nxt;
      fit_irq  <= stat_q[S_FI_STS]  & ctrl_q[C_FI_IEN];
      wdog_irq <= stat_q[S_WD_STS]  & ctrl_q[C_WD_IEN];
      dec_irq  <= stat_q[S_DEC_STS] & ctrl_q[C_DEC_IEN];
    end
  end

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (rst)
    fi_set |=> stat_q[S_FI_STS]);
  assert_wd_event_wins_R8: assert property (@(posedge clk) disable iff (rst)
    wd_set |=> stat_q[S_WD_STS]);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (stat_q[S_FI_STS] && !(stat_we && stat_wdata[S_FI_STS])) |=> stat_q[S_FI_STS]);
  assert_no_spurious_set_R6: assert property (@(posedge clk) disable iff (rst)
    (!stat_q[S_WD_STS] && !wd_set) |=> !stat_q[S_WD_STS]);
  assert_w1c_R7: assert property (@(posedge clk) disable iff (rst)
    (stat_we && stat_wdata[S_FI_STS] && !fi_set) |=> !stat_q[S_FI_STS]);
  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
    (stat_q[S_WD_STS] && ctrl_q[C_WD_IEN]) |=> wdog_irq);
  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[C_FI_IEN] |=> !fit_irq);
  assert_dec_set_R11: assert property (@(posedge clk) disable iff (rst)
    dec_set |=> stat_q[S_DEC_STS]);
endmodule

// File: rtl/tbt_tap_timers.sv
module tbt_tap_timers
  import tbt_pkg::*;
#(
  parameter logic [3:0][TAP_W-1:0] FI_TAPS = {6'd29, 6'd25, 6'd21, 6'd17},
  parameter logic [3:0][TAP_W-1:0] WD_TAPS = {6'd41, 6'd37, 6'd33, 6'd29}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             ext_mode,
  input  logic             ctrl_we,
  input  logic [REG_W-1:0] ctrl_wdata,
  input  logic             stat_we,
  input  logic [REG_W-1:0] stat_wdata,
  input  logic             dec_event,
  output logic [TB_W-1:0]  time_base,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] stat_q,
  output logic             fit_irq,
  output logic             wdog_irq,
  output logic             dec_irq,
  output logic             dec_status,
  output logic             dec_irq_en,
  output logic             dec_autoreload
);
  tap_mode_e        mode;
  logic [NSRC-1:0]  evt;
  logic [1:0]       per     [NSRC];
  logic [3:0]       per_ext [NSRC];
  logic [TAP_W-1:0] tap     [NSRC];

  assign mode = tap_mode_e'(ext_mode);

  assign per[SRC_FI]     = ctrl_q[C_FI_PER_LO +: 2];
  assign per_ext[SRC_FI] = ctrl_q[C_FI_EXT_LO +: 4];
  assign per[SRC_WD]     = ctrl_q[C_WD_PER_LO +: 2];
  assign per_ext[SRC_WD] = ctrl_q[C_WD_EXT_LO +: 4];

  tbt_time_base #(.W(TB_W)) u_tb (
    .clk(clk), .rst(rst), .tick_en(tick_en), .tb_q(time_base)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam logic [3:0][TAP_W-1:0] TBL = (g == SRC_FI) ? FI_TAPS : WD_TAPS;

    tbt_tap_decode #(.TAPS(TBL)) u_dec (
      .mode(mode), .per(per[g]), .per_ext(per_ext[g]), .tap_idx(tap[g])
    );

    tbt_edge_det #(.W(TB_W), .IW(TAP_W)) u_edge (
      .clk(clk), .rst(rst), .tb(time_base), .tap_idx(tap[g]), .evt(evt[g])
    );
  end

  tbt_regs u_regs (
    .clk(clk), .rst(rst),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .stat_we(stat_we), .stat_wdata(stat_wdata),
    .fi_set(evt[SRC_FI]), .wd_set(evt[SRC_WD]), .dec_set(dec_event),
    .ctrl_q(ctrl_q), .stat_q(stat_q),
    .fit_irq(fit_irq), .wdog_irq(wdog_irq), .dec_irq(dec_irq)
  );

  assign dec_status     = stat_q[S_DEC_STS];
  assign dec_irq_en     = ctrl_q[C_DEC_IEN];
  assign dec_autoreload = ctrl_q[C_AUTORELOAD];

  assert_reset_clean_R1: assert property (@(posedge clk)
    rst |=> (ctrl_q == '0 && stat_q == '0 && time_base == '0));
endmodule

// File: tb/tbt_tap_timers_bench.sv
module tbt_tap_timers_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        ext_mode = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic        stat_we = 1'b0;
  logic [31:0] stat_wdata = '0;
  logic        dec_event = 1'b0;
  logic [63:0] time_base;
  logic [31:0] ctrl_q, stat_q;
  logic        fit_irq, wdog_irq, dec_irq, dec_status, dec_irq_en, dec_autoreload;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // table mode taps: fixed-interval {1,2,3,4}, watchdog {2,3,4,5}
  tbt_tap_timers #(
    .FI_TAPS({6'd4, 6'd3, 6'd2, 6'd1}),
    .WD_TAPS({6'd5, 6'd4, 6'd3, 6'd2})
  ) u_tbt_tap_timers (
    .clk(clk), .rst(rst), .tick_en(tick_en), .ext_mode(ext_mode),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .stat_we(stat_we), .stat_wdata(stat_wdata), .dec_event(dec_event),
    .time_base(time_base), .ctrl_q(ctrl_q), .stat_q(stat_q),
    .fit_irq(fit_irq), .wdog_irq(wdog_irq), .dec_irq(dec_irq),
    .dec_status(dec_status), .dec_irq_en(dec_irq_en), .dec_autoreload(dec_autoreload)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic mode);
    ext_mode = mode;
    rst = 1'b1;
    cyc();
    cyc();
    rst = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [31:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    cyc();
    ctrl_we = 1'b0;
  endtask

  task automatic wr_stat(input logic [31:0] v);
    stat_we = 1'b1; stat_wdata = v;
    cyc();
    stat_we = 1'b0;
  endtask

  task automatic tick_to(input logic [63:0] v);
    while (time_base < v) begin
      tick_en = 1'b1;
      cyc();
      tick_en = 1'b0;
    end
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    check("R1 ctrl", ctrl_q, 0);
    check("R1 stat", stat_q, 0);
    check("R1 time base", time_base, 0);
    check("R1 irqs", {fit_irq, wdog_irq, dec_irq}, 0);
    wr_ctrl(32'hA5A5_A5A5);
    check("R3 readback", ctrl_q, 32'hA5A5_A5A5);
    check("R11 dec enable/autoreload", {dec_irq_en, dec_autoreload}, 2'b10);
    wr_ctrl(32'h0040_0000);
    check("R11 autoreload only", {dec_irq_en, dec_autoreload}, 2'b01);
  endtask

  task automatic t_tick();
    do_reset(1'b0);
    tick_to(3);
    cyc(); cyc();
    check("R2 held while idle", time_base, 3);
    tick_en = 1'b1; cyc(); cyc(); tick_en = 1'b0;
    check("R2 count", time_base, 5);
  endtask

  task automatic t_table_fit();
    do_reset(1'b0);
    wr_ctrl((32'd1 << 24) | (32'd1 << 23));   // period 1 -> tap 2, FIE
    tick_to(3); cyc(); cyc();
    check("R4 no event below tap", stat_q[26], 0);
    tick_to(4); cyc();
    check("R6 status set", stat_q[26], 1);
    check("R10 irq registered after status", fit_irq, 0);
    cyc();
    check("R10 fit irq", fit_irq, 1);
    wr_stat(32'd1 << 26);
    check("R7 cleared", stat_q[26], 0);
    tick_to(11); cyc(); cyc();
    check("R6 no event on fall", stat_q[26], 0);
    tick_to(12); cyc(); cyc();
    check("R6 next rise", stat_q[26], 1);
  endtask

  task automatic t_w1c_and_wins();
    do_reset(1'b0);
    wr_ctrl((32'd1 << 23) | (32'd1 << 27));   // tap 1 / tap 2
    tick_to(4); cyc(); cyc();
    check("R6 both set", {stat_q[30], stat_q[26]}, 2'b11);
    wr_stat(32'd0);
    check("R7 zero write keeps", {stat_q[30], stat_q[26]}, 2'b11);
    wr_stat(32'd1 << 30);
    check("R7 selective clear", {stat_q[30], stat_q[26]}, 2'b01);
    tick_to(5); cyc();
    tick_en = 1'b1; cyc();                   // tb=6, tap 1 rises
    tick_en = 1'b0; stat_we = 1'b1; stat_wdata = 32'd1 << 26;
    cyc();
    stat_we = 1'b0;
    check("R8 event wins over clear", stat_q[26], 1);
    wr_ctrl(32'd1 << 27);
    cyc();
    check("R10 fit irq drops with enable", fit_irq, 0);
  endtask

  task automatic t_retap();
    do_reset(1'b0);
    wr_ctrl((32'd2 << 24) | (32'd1 << 23));   // tap 3
    tick_to(4); cyc(); cyc();
    check("R9 tap3 quiet", stat_q[26], 0);
    wr_ctrl((32'd1 << 24) | (32'd1 << 23));   // tap 2, bit already 1
    cyc(); cyc(); cyc();
    check("R9 no event from retap", stat_q[26], 0);
    tick_to(12); cyc(); cyc();
    check("R9 real edge after retap", stat_q[26], 1);
  endtask

  task automatic t_extended();
    do_reset(1'b1);
    // watchdog: per 3, ext 0xE -> tap 4; fixed: per 2, ext 0xF -> tap 1
    wr_ctrl((32'd3 << 30) | (32'd1 << 27) | (32'hE << 17) |
            (32'd2 << 24) | (32'd1 << 23) | (32'hF << 13));
    tick_to(1); cyc(); cyc();
    check("R5 fixed quiet", stat_q[26], 0);
    tick_to(2); cyc(); cyc();
    check("R5 fixed tap 1", stat_q[26], 1);
    tick_to(15); cyc(); cyc();
    check("R5 watchdog quiet", stat_q[30], 0);
    tick_to(16); cyc(); cyc();
    check("R5 watchdog tap 4", stat_q[30], 1);
    check("R10 wdog irq", wdog_irq, 1);
    check("R7 reserved status bits", {stat_q[31], stat_q[29:28]}, 0);
  endtask

  task automatic t_dec();
    do_reset(1'b0);
    wr_ctrl(32'd1 << 26);
    dec_event = 1'b1; cyc(); dec_event = 1'b0;
    check("R11 dec status", dec_status, 1);
    check("R10 dec irq lag", dec_irq, 0);
    cyc();
    check("R10 dec irq", dec_irq, 1);
    wr_stat(32'd1 << 27);
    check("R7 dec clear", dec_status, 0);
    cyc();
    check("R10 dec irq drop", dec_irq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_tick();
    t_table_fit();
    t_w1c_and_wins();
    t_retap();
    t_extended();
    t_dec();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule